// File: doc/BRIEF.md
# Banked Indirect Register Window

This block lets a narrow host register bus reach several internal register banks without spending direct address space on each of them. Three directly addressed registers form the window: a bank-select register, an offset register and a data port. A host picks a bank once, loads an offset, and then reads or writes the data port. Each data-port access lands on the chosen bank at the stored offset.

The host bus is a single-cycle strobe interface. A write commits on the rising clock edge while the strobe is high. A read returns its byte combinationally in the same cycle as the strobe. Three banks are built in. Bank 0 holds video test-pattern settings, and its enable bit is also driven out of the block. Bank 1 is a plain read/write bank for link-transmitter settings. Bank 2 is a fixed identifier that cannot be written. All other bank numbers are empty.

Top module: `iwin_top`

## Requirements
- R1: After reset, the bank select and the offset are 0, every bank byte is 0 and `pg_enable` is low.
- R2: A write to direct address 0xB0 stores bits 7:2 of the write data as the bank number. A read of 0xB0 returns the bank number in bits 7:2, with bits 1:0 always 0.
- R3: A write to 0xB1 stores the 8-bit offset, and a read of 0xB1 returns it. Reads and writes of the data port never change the offset (no auto-increment).
- R4: A write to the data port 0xB2 updates the selected bank byte at the stored offset. The bank selection persists across any number of accesses until 0xB0 is written again.
- R5: A read of 0xB2 returns, in the same cycle, the byte at the stored offset of the selected bank.
- R6: In bank 0, offsets 0x01 to 0x1F are implemented. Offset 0x01 keeps only bit 0, and its other bits read 0. `pg_enable` follows that bit one cycle after the write. Offsets 0x02 to 0x1F keep all 8 bits.
- R7: In bank 1, offsets 0x00 to 0x0F are read/write and keep all 8 bits.
- R8: Bank 2 is read-only. For offset k below 6, the byte is (0x5A + 37*k) mod 256. Data-port writes to bank 2 change nothing.
- R9: Bank numbers 3 to 63, bank 0 offsets 0x00 and 0x20 to 0xFF, bank 1 offsets 0x10 to 0xFF, and bank 2 offsets 6 to 0xFF all read as 0x00. Writes to them are discarded and do not alias onto implemented bytes.
- R10: Direct addresses other than 0xB0 to 0xB2 read 0x00, and writes to them change nothing.
- R11: `hb_rdata` is 0x00 in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_en | input | 1 | Host access strobe, one cycle per access |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 8 | Direct register address |
| hb_wdata | input | 8 | Write data |
| hb_rdata | output | 8 | Read data, valid in the strobe cycle |
| pg_enable | output | 1 | Pattern-generator enable (bank 0, offset 0x01, bit 0) |

## Verification
The hardest case to reach from the ports is a write that must be discarded, for example to the identifier bank, an empty bank or an offset just past the end of a bank. The proof that it was discarded is only visible later, when the window is pointed back at an implemented byte and read.

The stimulus therefore first fills the implemented bytes with known patterns. It then mixes bank reselection, offset loads that straddle each bank's edge, and data-port writes. A reference model checks every read and `pg_enable` in every cycle, so any aliasing or leaked write shows up on the next read of the affected byte.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  // direct window register addresses (host map, fixed)
  localparam logic [7:0] WIN_SEL_ADDR  = 8'hB0;
  localparam logic [7:0] WIN_OFF_ADDR  = 8'hB1;
  localparam logic [7:0] WIN_DATA_ADDR = 8'hB2;

  // bank numbers
  localparam int BANK_PGEN  = 0;
  localparam int BANK_LTX   = 1;
  localparam int BANK_DIEID = 2;

  // identifier byte generator
  function automatic logic [7:0] id_byte(input logic [7:0] seed, input logic [7:0] k);
    logic [15:0] prod;
    prod = 16'(k) * 16'd37;
    return seed + prod[7:0];
  endfunction
endpackage

// File: rtl/iwin_decode.sv
module iwin_decode #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int SELW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hb_en,
  input  logic            hb_wr,
  input  logic [AW-1:0]   hb_addr,
  input  logic [DW-1:0]   hb_wdata,
  output logic [SELW-1:0] sel_o,
  output logic [DW-1:0]   off_o,
  output logic            data_we_o,
  output logic            data_re_o,
  output logic [DW-1:0]   direct_rdata_o
);
  import iwin_pkg::*;
  localparam int SHIFT = DW - SELW;

  logic            sel_hit, off_hit, data_hit;
  logic            sel_we, off_we;
  logic [SELW-1:0] sel_q, sel_d;
  logic [DW-1:0]   off_q, off_d;

  always_comb begin
    sel_hit   = (hb_addr == AW'(WIN_SEL_ADDR));
    off_hit   = (hb_addr == AW'(WIN_OFF_ADDR));
    data_hit  = (hb_addr == AW'(WIN_DATA_ADDR));
    sel_we    = hb_en & hb_wr & sel_hit;
    off_we    = hb_en & hb_wr & off_hit;
    data_we_o = hb_en & hb_wr & data_hit;
    data_re_o = hb_en & ~hb_wr & data_hit;
  end

  // next-state
  always_comb begin
    sel_d = sel_q;
    off_d = off_q;
    if (sel_we) sel_d = hb_wdata[DW-1:SHIFT];
    if (off_we) off_d = hb_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      off_q <= '0;
    end else begin
      sel_q <= sel_d;
      off_q <= off_d;
    end
  end

  // direct register read-back
  always_comb begin
    direct_rdata_o = '0;
    if (hb_en && !hb_wr) begin
      if (sel_hit)      direct_rdata_o = {sel_q, {SHIFT{1'b0}}};
      else if (off_hit) direct_rdata_o = off_q;
    end
  end

  assign sel_o = sel_q;
  assign off_o = off_q;
endmodule

// File: rtl/iwin_rw_bank.sv
module iwin_rw_bank #(
  parameter int          DW         = 8,
  parameter int          FIRST_OFF  = 0,
  parameter int          CELLS      = 16,
  parameter logic [7:0]  FIRST_MASK = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [DW-1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] first_o
);
  logic [CELLS-1:0]         hit;
  logic [CELLS-1:0][DW-1:0] cell_q;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam logic [DW-1:0] MASK = (i == 0) ? DW'(FIRST_MASK) : {DW{1'b1}};
    logic          cell_we;
    logic [DW-1:0] cell_d;

    always_comb begin
      hit[i]  = (off_i == DW'(FIRST_OFF + i));
      cell_we = we_i & hit[i];
      cell_d  = wdata_i & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q[i] <= '0;
      else if (cell_we) cell_q[i] <= cell_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (hit[i]) rdata_o = rdata_o | cell_q[i];
    end
  end

  assign first_o = cell_q[0];
endmodule

// File: rtl/iwin_id_bank.sv
module iwin_id_bank #(
  parameter int         DW       = 8,
  parameter int         ID_BYTES = 6,
  parameter logic [7:0] ID_SEED  = 8'h5A
) (
  input  logic [DW-1:0] off_i,
  output logic [DW-1:0] rdata_o
);
  import iwin_pkg::*;

  always_comb begin
    rdata_o = '0;
    if (off_i < DW'(ID_BYTES)) rdata_o = DW'(id_byte(ID_SEED, 8'(off_i)));
  end
endmodule

// File: rtl/iwin_top.sv
module iwin_top #(
  parameter int         AW       = 8,
  parameter int         DW       = 8,
  parameter int         SELW     = 6,
  parameter int         PG_LAST  = 31,
  parameter int         TX_BYTES = 16,
  parameter int         ID_BYTES = 6,
  parameter logic [7:0] ID_SEED  = 8'h5A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_en,
  input  logic          hb_wr,
  input  logic [AW-1:0] hb_addr,
  input  logic [DW-1:0] hb_wdata,
  output logic [DW-1:0] hb_rdata,
  output logic          pg_enable
);
  import iwin_pkg::*;
  localparam int PG_FIRST = 1;
  localparam int PG_CELLS = PG_LAST - PG_FIRST + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [SELW-1:0] win_sel;
  logic [DW-1:0]   win_off;
  logic            data_we, data_re;
  logic [DW-1:0]   direct_rdata;
  logic [DW-1:0]   pg_rdata, pg_first, tx_rdata, tx_first, id_rdata;
  logic            pg_we, tx_we;
  logic [DW-1:0]   bank_rdata;

  iwin_decode #(.AW(AW), .DW(DW), .SELW(SELW)) u_dec (
    .clk(clk), .rst_n(rst_q), .hb_en(hb_en), .hb_wr(hb_wr),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .sel_o(win_sel), .off_o(win_off),
    .data_we_o(data_we), .data_re_o(data_re),
    .direct_rdata_o(direct_rdata)
  );

  always_comb begin
    pg_we = data_we & (win_sel == SELW'(BANK_PGEN));
    tx_we = data_we & (win_sel == SELW'(BANK_LTX));
  end

  iwin_rw_bank #(.DW(DW), .FIRST_OFF(PG_FIRST), .CELLS(PG_CELLS), .FIRST_MASK(8'h01)) u_pgen (
    .clk(clk), .rst_n(rst_q), .we_i(pg_we), .off_i(win_off),
    .wdata_i(hb_wdata), .rdata_o(pg_rdata), .first_o(pg_first)
  );

  iwin_rw_bank #(.DW(DW), .FIRST_OFF(0), .CELLS(TX_BYTES), .FIRST_MASK(8'hFF)) u_ltx (
    .clk(clk), .rst_n(rst_q), .we_i(tx_we), .off_i(win_off),
    .wdata_i(hb_wdata), .rdata_o(tx_rdata), .first_o(tx_first)
  );

  iwin_id_bank #(.DW(DW), .ID_BYTES(ID_BYTES), .ID_SEED(ID_SEED)) u_id (
    .off_i(win_off), .rdata_o(id_rdata)
  );

  always_comb begin
    if (win_sel == SELW'(BANK_PGEN))       bank_rdata = pg_rdata;
    else if (win_sel == SELW'(BANK_LTX))   bank_rdata = tx_rdata;
    else if (win_sel == SELW'(BANK_DIEID)) bank_rdata = id_rdata;
    else                                   bank_rdata = '0;
  end

  always_comb begin
    hb_rdata  = data_re ? bank_rdata : direct_rdata;
    pg_enable = pg_first[0];
  end

  logic unused_ok;
  assign unused_ok = ^{tx_first, pg_first[DW-1:1]};
endmodule

// File: rtl/iwin_checker.sv
module iwin_checker #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int SELW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hb_en,
  input logic            hb_wr,
  input logic [AW-1:0]   hb_addr,
  input logic [DW-1:0]   hb_wdata,
  input logic [DW-1:0]   hb_rdata,
  input logic            pg_enable,
  input logic [SELW-1:0] win_sel,
  input logic [DW-1:0]   win_off
);
  import iwin_pkg::*;
  logic rd, data_acc;
  assign rd       = hb_en & ~hb_wr;
  assign data_acc = hb_en & (hb_addr == AW'(WIN_DATA_ADDR));

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> hb_rdata == '0);  // R11
  AST_SEL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hb_addr == AW'(WIN_SEL_ADDR)) |-> hb_rdata[1:0] == 2'b00);  // R2
  AST_NO_AUTOINC: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> $stable(win_off));  // R3
  AST_SEL_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    !(hb_en && hb_wr && hb_addr == AW'(WIN_SEL_ADDR)) |=> $stable(win_sel));  // R4
  AST_PG_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && hb_wr && win_sel == '0 && win_off == DW'(1)) |=> pg_enable == $past(hb_wdata[0]));  // R6
  AST_EMPTY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !hb_wr && win_sel > SELW'(BANK_DIEID)) |-> hb_rdata == '0);  // R9
  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hb_addr != AW'(WIN_SEL_ADDR) && hb_addr != AW'(WIN_OFF_ADDR)
        && hb_addr != AW'(WIN_DATA_ADDR)) |-> hb_rdata == '0);  // R10
endmodule

bind iwin_top iwin_checker #(.AW(AW), .DW(DW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_q), .hb_en(hb_en), .hb_wr(hb_wr), .hb_addr(hb_addr),
  .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .pg_enable(pg_enable),
  .win_sel(win_sel), .win_off(win_off)
);

// File: tb/iwin_top_test.sv
`timescale 1ns/1ps
module iwin_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hb_en, hb_wr;
  logic [7:0] hb_addr, hb_wdata;
  logic [7:0] hb_rdata;
  logic       pg_enable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_sel, m_off;
  int m_pg[256];
  int m_tx[256];

  always #4 clk = ~clk;

  iwin_top uut (
    .clk(clk), .rst_n(rst_n), .hb_en(hb_en), .hb_wr(hb_wr),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .pg_enable(pg_enable)
  );

  function automatic int bank_byte(int s, int o);
    if (s == 0 && o >= 1 && o <= 31) return m_pg[o];
    if (s == 1 && o <= 15) return m_tx[o];
    if (s == 2 && o <= 5) return (8'h5A + 37 * o) % 256;
    return 0;
  endfunction

  function automatic int model_read(int a);
    if (a == 8'hB0) return m_sel * 4;
    if (a == 8'hB1) return m_off;
    if (a == 8'hB2) return bank_byte(m_sel, m_off);
    return 0;
  endfunction

  function automatic string tag_of(bit en, bit wr, int a);
    if (!en || wr) return "R11";
    if (a == 8'hB0) return "R2";
    if (a == 8'hB1) return "R3";
    if (a != 8'hB2) return "R10";
    if (m_sel > 2) return "R9";
    if (bank_byte(m_sel, m_off) == 0) return "R9/R5";
    if (m_sel == 2) return "R8";
    if (m_sel == 1) return "R7";
    return "R6";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, compare before posedge, update model after it
  task automatic op(bit en, bit wr, int a, int d, string tag = "");
    string t;
    @(negedge clk);
    hb_en = en; hb_wr = wr; hb_addr = 8'(a); hb_wdata = 8'(d);
    #2;
    t = (tag == "") ? tag_of(en, wr, a) : tag;
    check(t, int'(hb_rdata), (en && !wr) ? model_read(a) : 0);
    check("R6 pg_enable", int'(pg_enable), m_pg[1] & 1);
    @(posedge clk);
    if (en && wr) begin
      if (a == 8'hB0) m_sel = d / 4;
      else if (a == 8'hB1) m_off = d;
      else if (a == 8'hB2) begin
        if (m_sel == 0 && m_off >= 1 && m_off <= 31) m_pg[m_off] = (m_off == 1) ? (d & 1) : d;
        else if (m_sel == 1 && m_off <= 15) m_tx[m_off] = d;
      end
    end
  endtask

  task automatic wr(int a, int d); op(1, 1, a, d); endtask
  task automatic rd(int a, string tag = ""); op(1, 0, a, 0, tag); endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_sel = 0; m_off = 0;
    foreach (m_pg[i]) begin m_pg[i] = 0; m_tx[i] = 0; end
    hb_en = 0; hb_wr = 0; hb_addr = 0; hb_wdata = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'hB0, "R1"); rd(8'hB1, "R1"); rd(8'hB2, "R1");
    for (int k = 1; k < 32; k++) begin wr(8'hB1, k); rd(8'hB2, "R1"); end

    // R2 selection with low bits set
    wr(8'hB0, 8'h07); rd(8'hB0, "R2");
    wr(8'hB0, 8'hFF); rd(8'hB0, "R2");

    // R6 pattern bank incl. enable bit masking
    wr(8'hB0, 8'h00);
    wr(8'hB1, 8'h01); wr(8'hB2, 8'hFF); rd(8'hB2, "R6"); op(0, 0, 0, 0, "R6");
    wr(8'hB2, 8'hFE); rd(8'hB2, "R6"); op(0, 0, 0, 0, "R6");
    wr(8'hB2, 8'h01);
    for (int k = 2; k < 32; k++) begin wr(8'hB1, k); wr(8'hB2, 255 - k * 3); end
    for (int k = 0; k < 34; k++) begin wr(8'hB1, k); rd(8'hB2, "R6"); end

    // R3 no auto-increment
    wr(8'hB1, 8'h05); rd(8'hB2, "R3"); rd(8'hB2, "R3"); wr(8'hB2, 8'h3C); rd(8'hB1, "R3"); rd(8'hB2, "R3");

    // R7 link bank and R4 persistence
    wr(8'hB0, 8'h04);
    for (int k = 0; k < 17; k++) begin wr(8'hB1, k); wr(8'hB2, k * 11 + 1); end
    for (int k = 0; k < 18; k++) begin wr(8'hB1, k); rd(8'hB2, "R7"); end
    wr(8'hB1, 8'h10); wr(8'hB2, 8'hAA); wr(8'hB1, 8'h00); rd(8'hB2, "R9");

    // R8 identifier bank, writes discarded
    wr(8'hB0, 8'h08);
    for (int k = 0; k < 8; k++) begin wr(8'hB1, k); wr(8'hB2, 8'h00); rd(8'hB2, "R8"); end

    // R9 empty banks, no aliasing
    for (int b = 3; b < 64; b += 15) begin
      wr(8'hB0, b * 4); wr(8'hB1, 8'h02); wr(8'hB2, 8'h77); rd(8'hB2, "R9");
    end
    wr(8'hB0, 8'h00); wr(8'hB1, 8'h02); rd(8'hB2, "R9");
    wr(8'hB1, 8'h22); wr(8'hB2, 8'h99); wr(8'hB1, 8'h02); rd(8'hB2, "R9");

    // R10 other direct addresses
    wr(8'h00, 8'h55); wr(8'hB3, 8'h55); wr(8'hAF, 8'h55);
    rd(8'h00, "R10"); rd(8'hB3, "R10"); rd(8'hAF, "R10");
    rd(8'hB0, "R10"); rd(8'hB1, "R10");

    // R11 idle / write cycles read zero
    op(0, 0, 8'hB2, 0, "R11"); op(1, 1, 8'hB0, 0, "R11");

    // random mix, reference model compared every cycle (R4 R5)
    void'($urandom(7));
    for (int n = 0; n < 6000; n++) begin
      int r, a, d;
      r = $urandom_range(0, 9);
      case (r)
        0: a = 8'hB0;
        1, 2: a = 8'hB1;
        3, 4, 5, 6, 7: a = 8'hB2;
        default: a = $urandom_range(0, 255);
      endcase
      d = $urandom_range(0, 255);
      if (a == 8'hB0) d = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 3) * 4 + $urandom_range(0, 3) : d;
      if (a == 8'hB1 && $urandom_range(0, 3) != 0) d = $urandom_range(0, 40);
      op($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, a, d);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule